// File: doc/BRIEF.md
# OFDM DATA Field Serializer with Additive Scrambler

This block turns one PSDU, delivered as a stream of octets, into the complete serial DATA field of an OFDM PHY frame, already scrambled. After a start pulse it emits a 16-bit all-zero SERVICE field. It then emits the PSDU octets, least significant bit first, followed by six tail bits. Last come enough zero pad bits to fill a whole number of OFDM symbols at the selected rate. Every bit passes through a 7-stage additive scrambler whose register is loaded from a seed input at the start. One bit leaves per clock cycle, qualified by a valid flag.

The PSDU octets arrive over a simple ready/valid handshake. A missing octet stalls the output for that cycle, and the resulting stream does not change. The length, rate, seed and tail option are all taken at the start pulse. A done strobe marks the final bit of the field. A seed of zero would lock the scrambler in the all-zero state, so it is refused and reported.

Top module: `dfb_top`

## Requirements
- R1: After reset, bit_valid, done, seed_err and byte_ready are all low.
- R2: A start pulse in idle with a nonzero seed produces, in this order: 16 zero SERVICE bits, the psdu_len octets with bit 0 of each octet first, 6 zero tail bits, then the pad bits. All of them are scrambled, one per bit_valid cycle.
- R3: The scrambler state x7..x1 is loaded with seed[6:0], where seed[6] goes to x7. For each emitted bit, fb = x7 XOR x4, the output is data XOR fb, and the state shifts so that x7..x2 takes x6..x1 and x1 takes fb.
- R4: The pad count is ceil((22 + 8*psdu_len)/N)*N - (22 + 8*psdu_len). N is selected by rate_sel codes 0 to 7 as 24, 36, 48, 72, 96, 144, 192 and 216. For example, psdu_len 100 at code 5 gives 42 pad bits and 864 bits in total.
- R5: With tail_zero high at start, the six tail bits leave as 0 while the scrambler still advances, so the pad bits keep the scrambled sequence.
- R6: With tail_zero low at start, the tail bits leave scrambled like any other bit.
- R7: An octet is taken only in a cycle where byte_ready and byte_valid are both high. byte_ready is high only when the next PSDU bit starts a new octet. A cycle with byte_ready high and byte_valid low produces no output bit in the following cycle. Stalls leave the emitted bit sequence unchanged.
- R8: done is high for exactly one cycle, together with the last pad bit. Afterwards, bit_valid, byte_ready and done stay low and byte_valid is ignored until the next start.
- R9: A start with seed 0 raises seed_err for one cycle and produces no frame.
- R10: A start pulse while a field is in progress is ignored, and the field in progress is unchanged.
- R11: With an all-zero PSDU, the output is the raw scrambler sequence for the seed, which repeats every 127 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a field when idle |
| seed | input | 7 | Scrambler initial state, sampled at start |
| rate_sel | input | 3 | Rate code selecting data bits per symbol |
| psdu_len | input | LEN_W | PSDU length in octets, sampled at start |
| tail_zero | input | 1 | Force tail outputs to zero, sampled at start |
| byte_in | input | 8 | PSDU octet |
| byte_valid | input | 1 | byte_in holds an octet |
| byte_ready | output | 1 | Block takes an octet this cycle if valid |
| bit_out | output | 1 | Scrambled DATA bit |
| bit_valid | output | 1 | bit_out is valid |
| done | output | 1 | Marks the final bit of the field |
| seed_err | output | 1 | One-cycle pulse on a start with a zero seed |

## Verification
The embedded assertions check the per-cycle rules on every clock. These are: done appears only on a valid bit and is followed by silence, a stalled octet yields no bit, a forced tail emits zeros, a refused seed produces no output, and the scrambler state never reaches zero. Only the bench scenarios can show the sequence-level behaviour. That covers the exact scrambled stream against an independent model, the pad length for each rate code and length, immunity of the stream to random stalls and stray starts, and the 127-bit period on an all-zero payload.

// File: rtl/dfb_pkg.sv
package dfb_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SERV,
        PH_PSDU,
        PH_TAIL,
        PH_PAD
    } phase_e;

    localparam int unsigned SERV_BITS = 16;
    localparam int unsigned TAIL_BITS = 6;
    localparam int unsigned MAX_NDBPS = 216;
    localparam int unsigned PAD_W     = $clog2(MAX_NDBPS);

    function automatic int unsigned rate_bits(input logic [2:0] code);
        case (code)
            3'd0:    return 24;
            3'd1:    return 36;
            3'd2:    return 48;
            3'd3:    return 72;
            3'd4:    return 96;
            3'd5:    return 144;
            3'd6:    return 192;
            default: return 216;
        endcase
    endfunction

endpackage

// File: rtl/dfb_pad_calc.sv
module dfb_pad_calc
    import dfb_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input  logic [LEN_W-1:0] len,
    input  logic [2:0]       rate,
    output logic [PAD_W-1:0] pad
);
    localparam int TOT_W = LEN_W + 4;

    logic [TOT_W-1:0] total;
    logic [PAD_W-1:0] pad_opt [8];

    assign total = TOT_W'(SERV_BITS + TAIL_BITS) + {1'b0, len, 3'b000};

    // one constant-divisor remainder unit per rate code
    for (genvar k = 0; k < 8; k++) begin : g_rate
        localparam int unsigned NB = rate_bits(3'(k));
        logic [TOT_W-1:0] rem;
        assign rem = total % TOT_W'(NB);
        assign pad_opt[k] = (rem == '0) ? '0 : PAD_W'(TOT_W'(NB) - rem);
    end

    assign pad = pad_opt[rate];

endmodule

// File: rtl/dfb_scrambler.sv
module dfb_scrambler (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [6:0] seed,
    input  logic       adv,
    input  logic       din,
    output logic       dout
);
    logic [6:0] s_d, s_q;
    logic       fb;

    assign fb   = s_q[6] ^ s_q[3];
    assign dout = din ^ fb;

    always_comb begin
        s_d = s_q;
        if (load)
            s_d = seed;
        else if (adv)
            s_d = {s_q[5:0], fb};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= 7'h7f;
        else        s_q <= s_d;
    end

    assert_load_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (seed != 7'd0));

    assert_state_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q != 7'd0);

    assert_hold_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !adv) |=> $stable(s_q));

endmodule

// File: rtl/dfb_top.sv
module dfb_top
    import dfb_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [6:0]       seed,
    input  logic [2:0]       rate_sel,
    input  logic [LEN_W-1:0] psdu_len,
    input  logic             tail_zero,
    input  logic [7:0]       byte_in,
    input  logic             byte_valid,
    output logic             byte_ready,
    output logic             bit_out,
    output logic             bit_valid,
    output logic             done,
    output logic             seed_err
);
    localparam int CNT_W = LEN_W + 3;

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic [6:0]       sh;
        logic [PAD_W-1:0] pad;
        logic [LEN_W-1:0] len;
        logic             tz;
        logic             obit;
        logic             ovld;
        logic             odone;
        logic             oerr;
    } regs_t;

    regs_t r_d, r_q;

    logic [PAD_W-1:0] pad_calc;
    logic             scr_load, scr_adv, scr_din, scr_dout;
    logic             emit, force0;

    dfb_pad_calc #(.LEN_W(LEN_W)) pad_i (
        .len  (psdu_len),
        .rate (rate_sel),
        .pad  (pad_calc)
    );

    dfb_scrambler scr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (scr_load),
        .seed  (seed),
        .adv   (scr_adv),
        .din   (scr_din),
        .dout  (scr_dout)
    );

    assign byte_ready = (r_q.ph == PH_PSDU) && (r_q.cnt[2:0] == 3'd0);

    always_comb begin
        r_d       = r_q;
        r_d.ovld  = 1'b0;
        r_d.odone = 1'b0;
        r_d.oerr  = 1'b0;
        scr_load  = 1'b0;
        scr_din   = 1'b0;
        emit      = 1'b0;
        force0    = 1'b0;

        case (r_q.ph)
            PH_IDLE: begin
                if (start) begin
                    if (seed == 7'd0) begin
                        r_d.oerr = 1'b1;
                    end else begin
                        scr_load = 1'b1;
                        r_d.ph   = PH_SERV;
                        r_d.cnt  = '0;
                        r_d.pad  = pad_calc;
                        r_d.len  = psdu_len;
                        r_d.tz   = tail_zero;
                    end
                end
            end
            PH_SERV: begin
                emit = 1'b1;
                if (r_q.cnt == CNT_W'(SERV_BITS - 1)) begin
                    r_d.cnt = '0;
                    r_d.ph  = (r_q.len == '0) ? PH_TAIL : PH_PSDU;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            PH_PSDU: begin
                if (r_q.cnt[2:0] == 3'd0) begin
                    if (byte_valid) begin
                        emit    = 1'b1;
                        scr_din = byte_in[0];
                        r_d.sh  = byte_in[7:1];
                    end
                end else begin
                    emit    = 1'b1;
                    scr_din = r_q.sh[0];
                    r_d.sh  = {1'b0, r_q.sh[6:1]};
                end
                if (emit) begin
                    if (r_q.cnt == {r_q.len - 1'b1, 3'b111}) begin
                        r_d.cnt = '0;
                        r_d.ph  = PH_TAIL;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
            PH_TAIL: begin
                emit   = 1'b1;
                force0 = r_q.tz;
                if (r_q.cnt == CNT_W'(TAIL_BITS - 1)) begin
                    r_d.cnt = '0;
                    if (r_q.pad == '0) begin
                        r_d.ph    = PH_IDLE;
                        r_d.odone = 1'b1;
                    end else begin
                        r_d.ph = PH_PAD;
                    end
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            PH_PAD: begin
                emit    = 1'b1;
                r_d.pad = r_q.pad - 1'b1;
                if (r_q.pad == PAD_W'(1)) begin
                    r_d.ph    = PH_IDLE;
                    r_d.odone = 1'b1;
                end
            end
            default: r_d.ph = PH_IDLE;
        endcase

        if (emit) begin
            r_d.ovld = 1'b1;
            r_d.obit = force0 ? 1'b0 : scr_dout;
        end
    end

    assign scr_adv = emit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.ph <= PH_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign bit_out   = r_q.obit;
    assign bit_valid = r_q.ovld;
    assign done      = r_q.odone;
    assign seed_err  = r_q.oerr;

    assert_done_on_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> bit_valid);

    assert_quiet_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!bit_valid && !byte_ready));

    assert_err_no_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
        seed_err |=> (!bit_valid && !byte_ready));

    assert_stall_no_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_ready && !byte_valid) |=> !bit_valid);

    assert_tail_forced_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ph == PH_TAIL && r_q.tz) |=> (bit_valid && !bit_out));

    assert_pad_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ph == PH_PAD) |-> (r_q.pad != '0));

endmodule

// File: tb/dfb_top_tb_top.sv
module dfb_top_tb_top;
    localparam int LEN_W = 12;
    localparam int MAXB  = 4096;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [6:0]       seed = 7'h5d;
    logic [2:0]       rate_sel = 3'd0;
    logic [LEN_W-1:0] psdu_len = '0;
    logic             tail_zero = 1'b0;
    logic [7:0]       byte_in = 8'h00;
    logic             byte_valid = 1'b0;
    logic             byte_ready, bit_out, bit_valid, done, seed_err;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit finished = 1'b0;

    logic [7:0] psdu [MAXB];
    logic       expb [MAXB];
    logic       rawb [MAXB];
    logic       gotb [MAXB];
    int         exp_n;

    always #10 clk = ~clk;

    dfb_top #(.LEN_W(LEN_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .seed(seed),
        .rate_sel(rate_sel), .psdu_len(psdu_len), .tail_zero(tail_zero),
        .byte_in(byte_in), .byte_valid(byte_valid), .byte_ready(byte_ready),
        .bit_out(bit_out), .bit_valid(bit_valid), .done(done), .seed_err(seed_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int nbits_of(input int code);
        int t[8] = '{24, 36, 48, 72, 96, 144, 192, 216};
        return t[code];
    endfunction

    function automatic int pad_of(input int len, input int code);
        int tot = 22 + 8 * len;
        int n = nbits_of(code);
        return (n - (tot % n)) % n;
    endfunction

    // reference: raw scrambled stream per R2/R3/R5
    function automatic void build_exp(input int len, input int code,
                                      input logic [6:0] sd, input bit tz);
        logic [7:1] x = sd;
        int pos = 0;
        int total = 22 + 8 * len + pad_of(len, code);
        for (int i = 0; i < total; i++) begin
            logic d, f;
            if (i >= 16 && i < 16 + 8 * len) d = psdu[(i - 16) / 8][(i - 16) % 8];
            else d = 1'b0;
            f = x[7] ^ x[4];
            rawb[pos] = f;
            expb[pos] = d ^ f;
            if (tz && i >= 16 + 8 * len && i < 22 + 8 * len) expb[pos] = 1'b0;
            x = {x[6:1], f};
            pos++;
        end
        exp_n = total;
    endfunction

    task automatic run_frame(input int len, input int code, input logic [6:0] sd,
                             input bit tz, input int stall_pct, input bit poke,
                             input bit zero_data);
        int idx = 0, got = 0, done_at = -1, cyc = 0, mism = 0, first_bad = -1, dones = 0;
        for (int i = 0; i < len; i++) psdu[i] = zero_data ? 8'h00 : 8'($urandom);
        build_exp(len, code, sd, tz);
        @(negedge clk);
        start = 1'b1; seed = sd; rate_sel = 3'(code);
        psdu_len = LEN_W'(len); tail_zero = tz;
        @(negedge clk);
        start = 1'b0;
        while (done_at < 0 && cyc < 30000) begin
            if (bit_valid) begin
                if (got < MAXB) gotb[got] = bit_out;
                if (done) begin done_at = got; dones++; end
                got++;
            end else if (done) begin
                dones++;
            end
            byte_valid = (($urandom % 100) >= stall_pct);
            byte_in = (idx < len) ? psdu[idx] : 8'hxx;
            if (byte_ready && byte_valid) idx++;
            if (poke && (cyc % 37) == 5) begin
                start = 1'b1; seed = ~sd | 7'h01;
                rate_sel = 3'(code + 3); psdu_len = LEN_W'(len + 9); tail_zero = ~tz;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        for (int i = 0; i < exp_n && i < got && i < MAXB; i++)
            if (gotb[i] !== expb[i]) begin
                mism++;
                if (first_bad < 0) first_bad = i;
            end
        chk(got == exp_n, "R4 field length", got, exp_n);
        chk(mism == 0, poke ? "R10 stream under stray start" :
            (tz ? "R5 stream with forced tail" : "R2/R3 scrambled stream (R6)"), mism, 0);
        chk(done_at == exp_n - 1 && dones == 1, "R8 done on last bit", done_at, exp_n - 1);
        chk(idx == len, "R7 octets taken", idx, len);
        if (zero_data) begin
            int rm = 0;
            for (int i = 0; i < exp_n && i < got; i++) if (gotb[i] !== rawb[i]) rm++;
            for (int i = 0; i + 127 < got; i++) if (gotb[i] !== gotb[i + 127]) rm++;
            chk(rm == 0, "R11 raw sequence and period", rm, 0);
        end
        // R8: silent afterwards, byte_valid ignored
        begin
            int noisy = 0;
            for (int k = 0; k < 6; k++) begin
                byte_valid = 1'b1;
                @(negedge clk);
                if (bit_valid || byte_ready || done) noisy++;
            end
            byte_valid = 1'b0;
            chk(noisy == 0, "R8 idle after done", noisy, 0);
        end
    endtask

    initial begin : watchdog
        while (!finished && cycles < 190000) begin
            @(posedge clk);
            cycles++;
        end
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!bit_valid, "R1 bit_valid reset", bit_valid, 0);
        chk(!done, "R1 done reset", done, 0);
        chk(!seed_err, "R1 seed_err reset", seed_err, 0);
        chk(!byte_ready, "R1 byte_ready reset", byte_ready, 0);

        // R9: zero seed refused
        begin
            int errs = 0, vld = 0;
            start = 1'b1; seed = 7'd0; psdu_len = LEN_W'(4); rate_sel = 3'd0;
            @(negedge clk);
            start = 1'b0;
            for (int k = 0; k < 8; k++) begin
                if (seed_err) errs++;
                if (bit_valid || byte_ready) vld++;
                @(negedge clk);
            end
            chk(errs == 1, "R9 seed_err pulse", errs, 1);
            chk(vld == 0, "R9 no frame on zero seed", vld, 0);
        end

        // directed corners
        run_frame(100, 5, 7'b1011101, 1'b0, 0, 1'b0, 1'b0);   // R4: 42 pad, 864 bits
        chk(exp_n == 864, "R4 100 octets at code 5", exp_n, 864);
        run_frame(100, 5, 7'b1011101, 1'b1, 0, 1'b0, 1'b0);   // R5
        run_frame(0, 0, 7'h01, 1'b0, 20, 1'b0, 1'b0);          // empty PSDU
        run_frame(40, 7, 7'h7f, 1'b0, 0, 1'b0, 1'b1);          // R11
        run_frame(30, 2, 7'h33, 1'b1, 30, 1'b1, 1'b0);         // R10 with stalls
        run_frame(255, 3, 7'h4a, 1'b0, 10, 1'b0, 1'b0);

        // constrained random mix
        for (int t = 0; t < 30; t++) begin
            int len = $urandom % 61;
            int code = $urandom % 8;
            logic [6:0] sd = 7'($urandom % 127 + 1);
            run_frame(len, code, sd, 1'($urandom), $urandom % 50, (t % 5) == 4, 1'b0);
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule